// File: doc/BRIEF.md
# RGB Pixel to Bus Word Packer

The packer sits between a video scaler and the write FIFO of a bus-master DMA channel. It takes one RGB pixel per cycle over a valid/ready handshake, along with an end-of-line marker. It turns the pixel stream into 32-bit words. Each word leaves with a 4-bit byte-lane enable mask and a flag that marks the final word of a line.

There are two output formats:

- **Wide format.** Each pixel becomes one word: three colour bytes plus an alpha byte. The alpha byte is either one key bit copied into all eight positions, or a byte taken from a separate alpha input.
- **Dense format.** Each pixel becomes three bytes, laid end to end across word boundaries, so four pixels fill three words. The first byte of each line goes into the lane given by the low two bits of the DMA base address. The lanes of the first and last words that hold no pixel bytes are disabled.

An optional byte swap can be applied to every word for endianness. The choices are a full reversal of the four bytes, or a swap of the two bytes inside each half-word.

Colour values pass through unchanged: 0x00 is black and 0xFF is white, with no clamping or offset. The format, swap and phase settings are captured with the first pixel of each line.

Top module: `rgb_word_packer`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: When cfg_dense=0, each accepted pixel yields exactly one word. Lane 0 (bits 7:0) holds blue, lane 1 green, lane 2 red and lane 3 alpha. out_be is 4'b1111 and out_last equals the pixel's in_eol. The word is offered on the clock edge after the pixel is accepted.
- R3: In the wide format, cfg_alpha_sel=0 fills the alpha byte with eight copies of in_key. cfg_alpha_sel=1 takes the alpha byte from in_alpha.
- R4: When cfg_dense=1, pixels become the byte stream blue, green, red, pixel after pixel. The stream fills lanes from 0 upward and wraps into the next word. With phase 0, four pixels give exactly three words, each with out_be 4'b1111.
- R5: In the dense format, the first byte of a line goes into lane cfg_phase. The lanes below it in the line's first word are disabled.
- R6: When a dense line ends in the middle of a word, that word is sent with out_last set and its unfilled upper lanes disabled. If the final pixel also completed a word, the spilled bytes follow as one extra word. The next line starts again at the programmed phase.
- R7: cfg_swap=0 leaves words unchanged. cfg_swap=1 swaps lanes 0 and 1, and lanes 2 and 3. cfg_swap=2 or 3 moves lane l to lane 3-l. The bits of out_be move together with their bytes.
- R8: While a word is held (out_valid high, out_ready low), in_ready is low and the word stays stable. No byte is lost or repeated across a stall.
- R9: Changes to cfg_dense, cfg_swap, cfg_alpha_sel or cfg_phase made after the first pixel of a line has been accepted have no effect until the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dense | input | 1 | 1 selects the dense three-byte format, 0 the wide format |
| cfg_alpha_sel | input | 1 | Alpha source in the wide format: 0 uses the replicated key bit, 1 uses in_alpha |
| cfg_swap | input | 2 | Byte swap mode: 0 none, 1 half-word swap, 2 or 3 full reversal |
| cfg_phase | input | 2 | Starting byte lane of a dense line |
| in_valid | input | 1 | A pixel is present |
| in_ready | output | 1 | The packer accepts the pixel |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| in_key | input | 1 | Colour key bit |
| in_alpha | input | 8 | Alpha byte from the separate alpha stream |
| in_eol | input | 1 | This pixel is the last one of its line |
| out_valid | output | 1 | A word is offered |
| out_ready | input | 1 | The FIFO takes the word |
| out_data | output | 32 | Packed word |
| out_be | output | 4 | Byte-lane enables |
| out_last | output | 1 | Final word of the line |

## Verification
Any word that a pixel completes is offered on the clock edge right after the pixel is accepted. A spill word that follows an end-of-line is offered one cycle after that, or later if the FIFO is still holding back. The bench never checks fixed cycle offsets. Its driver builds each line's expected words from a byte-stream model and queues them. The monitor samples at the falling edge and pops one expected word for each handshake it sees, so the checks stay correct under random backpressure. In every cycle where the output is held, the monitor also checks that in_ready is low.

// File: rtl/rgb_word_packer.sv
module rgb_word_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_dense,
  input  logic        cfg_alpha_sel,
  input  logic [1:0]  cfg_swap,
  input  logic [1:0]  cfg_phase,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_r,
  input  logic [7:0]  in_g,
  input  logic [7:0]  in_b,
  input  logic        in_key,
  input  logic [7:0]  in_alpha,
  input  logic        in_eol,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [3:0]  out_be,
  output logic        out_last
);

  function automatic logic [31:0] swap_d(input logic [31:0] d, input logic [1:0] m);
    case (m)
      2'd0:    swap_d = d;
      2'd1:    swap_d = {d[23:16], d[31:24], d[7:0], d[15:8]};
      default: swap_d = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  function automatic logic [3:0] swap_be(input logic [3:0] b, input logic [1:0] m);
    case (m)
      2'd0:    swap_be = b;
      2'd1:    swap_be = {b[2], b[3], b[0], b[1]};
      default: swap_be = {b[0], b[1], b[2], b[3]};
    endcase
  endfunction

  logic        line_start, flush_pend;
  logic        lat_dense, lat_asel;
  logic [1:0]  lat_swap;
  logic [1:0]  ptr;
  logic [31:0] acc_d;
  logic [3:0]  acc_be;

  wire slot_free = !out_valid || out_ready;
  assign in_ready = !flush_pend && slot_free;
  wire accept = in_valid && in_ready;

  wire       dense = line_start ? cfg_dense     : lat_dense;
  wire       asel  = line_start ? cfg_alpha_sel : lat_asel;
  wire [1:0] swp   = line_start ? cfg_swap      : lat_swap;
  wire [1:0] p     = line_start ? (cfg_dense ? cfg_phase : 2'd0) : ptr;
  wire [31:0] base_d  = line_start ? 32'd0 : acc_d;
  wire [3:0]  base_be = line_start ? 4'd0  : acc_be;

  wire [7:0]  alpha = asel ? in_alpha : {8{in_key}};
  wire [23:0] pix   = {in_r, in_g, in_b};
  wire [63:0] m_d   = {32'd0, base_d} | ({40'd0, pix} << {p, 3'b000});
  wire [7:0]  m_be  = {4'd0, base_be} | (8'b0000_0111 << p);
  wire [2:0]  np    = {1'b0, p} + 3'd3;
  wire        wrap  = np[2];

  logic        emit, e_last, n_flush;
  logic [31:0] e_d, n_acc;
  logic [3:0]  e_be, n_be;
  logic [1:0]  n_ptr;

  always_comb begin
    emit    = 1'b0;
    e_d     = m_d[31:0];
    e_be    = m_be[3:0];
    e_last  = in_eol;
    n_acc   = m_d[31:0];
    n_be    = m_be[3:0];
    n_ptr   = np[1:0];
    n_flush = 1'b0;
    if (!dense) begin
      emit  = 1'b1;
      e_d   = {alpha, pix};
      e_be  = 4'hF;
      n_acc = 32'd0;
      n_be  = 4'd0;
      n_ptr = 2'd0;
    end else if (wrap) begin
      emit    = 1'b1;
      n_acc   = m_d[63:32];
      n_be    = m_be[7:4];
      e_last  = in_eol && (np[1:0] == 2'd0);
      n_flush = in_eol && (np[1:0] != 2'd0);
    end else if (in_eol) begin
      emit = 1'b1;
    end
    if (in_eol && !n_flush) begin
      n_acc = 32'd0;
      n_be  = 4'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_start <= 1'b1;
      flush_pend <= 1'b0;
      lat_dense  <= 1'b0;
      lat_asel   <= 1'b0;
      lat_swap   <= 2'd0;
      ptr        <= 2'd0;
      acc_d      <= 32'd0;
      acc_be     <= 4'd0;
      out_valid  <= 1'b0;
      out_data   <= 32'd0;
      out_be     <= 4'd0;
      out_last   <= 1'b0;
    end else if (flush_pend && slot_free) begin
      out_valid  <= 1'b1;
      out_data   <= swap_d(acc_d, lat_swap);
      out_be     <= swap_be(acc_be, lat_swap);
      out_last   <= 1'b1;
      flush_pend <= 1'b0;
      acc_d      <= 32'd0;
      acc_be     <= 4'd0;
    end else if (accept) begin
      if (line_start) begin
        lat_dense <= cfg_dense;
        lat_asel  <= cfg_alpha_sel;
        lat_swap  <= cfg_swap;
      end
      line_start <= in_eol;
      acc_d      <= n_acc;
      acc_be     <= n_be;
      ptr        <= n_ptr;
      flush_pend <= n_flush;
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= swap_d(e_d, swp);
        out_be    <= swap_be(e_be, swp);
        out_last  <= e_last;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

module rgb_word_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic [3:0]  out_be,
  input logic        out_last
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_HELD_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be) && $stable(out_last)); // R8
  AST_SOME_LANE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_be != 4'd0); // R6
  AST_NO_TAKE_WHEN_IDLE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid || out_ready); // R8
endmodule

bind rgb_word_packer rgb_word_packer_chk chk_i (.*);

// File: tb/rgb_word_packer_tb_top.sv
module rgb_word_packer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dense = 1'b0, cfg_alpha_sel = 1'b0;
  logic [1:0] cfg_swap = 2'd0, cfg_phase = 2'd0;
  logic in_valid = 1'b0, in_key = 1'b0, in_eol = 1'b0;
  logic in_ready;
  logic [7:0] in_r = 8'd0, in_g = 8'd0, in_b = 8'd0, in_alpha = 8'd0;
  logic out_valid, out_last;
  logic out_ready = 1'b1;
  logic [31:0] out_data;
  logic [3:0] out_be;

  int checks = 0, errs = 0, cyc = 0;
  bit bp_en = 1'b0;

  logic [31:0] q_d[$];
  logic [3:0]  q_be[$];
  logic        q_last[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  rgb_word_packer dut_i (.*);

  always @(posedge clk) begin
    #1;
    out_ready = bp_en ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready !== 1'b0) begin
          errs++;
          $display("FAIL R8 in_ready during stall: actual=%b expected=0", in_ready);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (q_d.size() == 0) begin
          errs++;
          $display("FAIL R6 extra word: actual=%h/%b expected=none", out_data, out_be);
        end else begin
          logic [31:0] d; logic [3:0] b; logic l; string t;
          d = q_d.pop_front(); b = q_be.pop_front(); l = q_last.pop_front(); t = q_tag.pop_front();
          if (out_data !== d || out_be !== b || out_last !== l) begin
            errs++;
            $display("FAIL %s word: actual=%h be=%b last=%b expected=%h be=%b last=%b",
                     t, out_data, out_be, out_last, d, b, l);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++; errs++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic push(input logic [31:0] raw, input logic [3:0] be, input logic last,
                      input logic [1:0] sw, input string tag);
    logic [31:0] d; logic [3:0] b;
    d = '0; b = '0;
    for (int l = 0; l < 4; l++) begin
      int s;
      s = (sw == 2'd0) ? l : (sw == 2'd1) ? (l ^ 1) : (3 - l);
      d[8*l +: 8] = raw[8*s +: 8];
      b[l] = be[s];
    end
    q_d.push_back(d); q_be.push_back(b); q_last.push_back(last); q_tag.push_back(tag);
  endtask

  task automatic send_line(input int n, input bit dense, input bit asel, input logic [1:0] sw,
                           input logic [1:0] ph, input int seed, input bit mid_change, input string tag);
    logic [7:0] pr[16], pg[16], pb[16], pa[16];
    logic pk[16];
    logic [7:0] stream[48];
    for (int i = 0; i < n; i++) begin
      pr[i] = 8'(seed + 17 * i);
      pg[i] = 8'(seed * 3 + 29 * i + 5);
      pb[i] = 8'(seed + 71 * i + 11);
      pa[i] = 8'(200 - 13 * i);
      pk[i] = 1'(i + seed);
    end
    if (!dense) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] a;
        a = asel ? pa[i] : {8{pk[i]}};
        push({a, pr[i], pg[i], pb[i]}, 4'hF, i == n - 1, sw, tag);
      end
    end else begin
      int total, nw;
      total = 3 * n;
      for (int i = 0; i < n; i++) begin
        stream[3*i] = pb[i]; stream[3*i+1] = pg[i]; stream[3*i+2] = pr[i];
      end
      nw = (int'(ph) + total + 3) / 4;
      for (int k = 0; k < nw; k++) begin
        logic [31:0] raw; logic [3:0] be;
        raw = '0; be = '0;
        for (int l = 0; l < 4; l++) begin
          int idx;
          idx = 4 * k + l - int'(ph);
          if (idx >= 0 && idx < total) begin
            raw[8*l +: 8] = stream[idx];
            be[l] = 1'b1;
          end
        end
        push(raw, be, k == nw - 1, sw, tag);
      end
    end
    for (int i = 0; i < n; i++) begin
      bit ok;
      if (i == 0) begin
        cfg_dense = dense; cfg_alpha_sel = asel; cfg_swap = sw; cfg_phase = ph;
      end
      if (i == 1 && mid_change) begin
        cfg_dense = ~dense; cfg_alpha_sel = ~asel; cfg_swap = sw + 2'd2; cfg_phase = ph + 2'd2;
      end
      in_valid = 1'b1; in_r = pr[i]; in_g = pg[i]; in_b = pb[i];
      in_alpha = pa[i]; in_key = pk[i]; in_eol = (i == n - 1);
      do begin
        @(negedge clk); ok = in_ready;
        @(posedge clk); #1;
      end while (!ok);
    end
    in_valid = 1'b0; in_eol = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && q_d.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errs++;
      $display("FAIL R1 reset: actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
    @(posedge clk); #1;

    send_line(3, 1'b0, 1'b0, 2'd0, 2'd0, 1, 1'b0, "R2_R3_key");
    send_line(3, 1'b0, 1'b1, 2'd2, 2'd1, 9, 1'b0, "R3_R7_alpha_rev");
    send_line(2, 1'b0, 1'b0, 2'd1, 2'd0, 4, 1'b0, "R2_R7_half");
    send_line(4, 1'b1, 1'b0, 2'd0, 2'd0, 7, 1'b0, "R4_dense_ph0");
    send_line(5, 1'b1, 1'b0, 2'd0, 2'd1, 3, 1'b0, "R5_dense_ph1");
    send_line(2, 1'b1, 1'b0, 2'd0, 2'd3, 5, 1'b0, "R6_spill_ph3");
    send_line(1, 1'b1, 1'b0, 2'd0, 2'd2, 8, 1'b0, "R6_single_ph2");
    send_line(3, 1'b1, 1'b0, 2'd1, 2'd0, 2, 1'b0, "R7_dense_half");
    send_line(3, 1'b1, 1'b0, 2'd3, 2'd1, 6, 1'b0, "R7_dense_rev");
    drain();
    bp_en = 1'b1;
    send_line(7, 1'b1, 1'b0, 2'd0, 2'd3, 11, 1'b0, "R8_bp_dense");
    send_line(5, 1'b0, 1'b1, 2'd0, 2'd0, 12, 1'b0, "R8_bp_wide");
    send_line(2, 1'b1, 1'b0, 2'd2, 2'd3, 13, 1'b0, "R8_R6_bp_spill");
    drain();
    bp_en = 1'b0;
    send_line(4, 1'b1, 1'b0, 2'd0, 2'd1, 14, 1'b1, "R9_midline_cfg");
    send_line(2, 1'b0, 1'b1, 2'd0, 2'd0, 15, 1'b0, "R9_next_line");
    drain();

    checks++;
    if (q_d.size() != 0) begin
      errs++;
      $display("FAIL R8 missing words: actual=%0d left expected=0", q_d.size());
    end
    summary();
    $finish;
  end
endmodule